// File: doc/BRIEF.md
# Indirect Jump Bus-Cycle Sequencer

This block runs the bus cycles of two control-transfer operations of an 8-bit CPU: a jump to an absolute address, and a jump through a pointer held in memory. It takes an opcode and the current program counter through a valid/ready handshake. It then issues one read per clock to a synchronous memory. The memory returns `rd_data` for the address driven in the same cycle, and the block captures it at the rising edge that ends that cycle. The block collects the operand bytes and, where the opcode calls for it, the two pointed-to bytes. In the last cycle it presents the complete 16-bit target and asserts `pc_load`, so that both halves of the program counter change together.

The parameter `FIX_WRAP` picks one of two variants. With `FIX_WRAP = 0`, the indirect jump takes 5 cycles. Its second pointer read stays inside the pointer's page, so a pointer ending in FF fetches its high byte from offset 00 of the same page. The `wrap_hit` pulse marks the cycle in which this happens. With `FIX_WRAP = 1`, the indirect jump takes 6 cycles. The fourth cycle is a dummy read at the pointer, and the second pointer read uses the full 16-bit pointer plus one.

The opcode channel applies back-pressure. `op_ready` is high only while the sequencer is idle, and a transfer happens on a rising edge where `op_valid` and `op_ready` are both high. The source must hold `op_code` and `pc_in` stable while `op_valid` is high and `op_ready` is low. An accepted opcode that is neither jump is dropped.

Top module: `ind_jump_seq`

## Requirements
- R1: An opcode is taken only on a rising edge with `op_valid` and `op_ready` both high. `op_ready` is high exactly when `busy` is low. A jump opcode that is taken makes `busy` high from the next cycle.
- R2: The absolute jump (`op_code` 8'h4C) runs 3 busy cycles. It drives `addr` = PC, PC+1 and PC+2 in that order, with each sum taken modulo 2^16. `rd_en` is high in every busy cycle and low whenever the block is idle.
- R3: `pc_load` is high for exactly one cycle, the last busy cycle of an operation. In that cycle `pc_out` = {data read in that cycle, earlier low byte}. For the absolute jump the earlier low byte is the byte read at PC+1. For the indirect jump it is the byte read at the pointer.
- R4: The indirect jump (`op_code` 8'h6C) drives PC, PC+1 and PC+2 in its first three cycles, the same as the absolute jump. The pointer is {byte at PC+2, byte at PC+1}, and `pc_load` stays low in those three cycles.
- R5: With `FIX_WRAP = 0` the indirect jump runs 5 cycles. Cycle 4 reads the pointer P. Cycle 5 reads {P[15:8], P[7:0]+1 mod 256}.
- R6: With `FIX_WRAP = 1` the indirect jump runs 6 cycles. Cycle 4 is a dummy read at P whose data is discarded. Cycle 5 reads P, and cycle 6 reads P+1 modulo 2^16.
- R7: `wrap_hit` is high only in the last cycle of an indirect jump with `FIX_WRAP = 0` and P[7:0] = 8'hFF. It is never high with `FIX_WRAP = 1`.
- R8: An opcode other than 8'h4C and 8'h6C is consumed when taken but starts no bus cycle. `busy`, `rd_en` and `pc_load` stay low.
- R9: During and right after reset, `busy`, `rd_en`, `pc_load` and `wrap_hit` are low, `addr` is 0 and `op_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Opcode and PC offered |
| op_ready | output | 1 | Sequencer idle, offer is taken |
| op_code | input | 8 | Opcode of the offered operation |
| pc_in | input | 16 | Address of the opcode byte |
| addr | output | 16 | Read address for the current cycle |
| rd_en | output | 1 | Read strobe, high in every busy cycle |
| rd_data | input | 8 | Data for `addr`, captured at the end of the cycle |
| pc_out | output | 16 | New program counter, valid with `pc_load` |
| pc_load | output | 1 | One-cycle load strobe for the program counter |
| busy | output | 1 | Operation in progress |
| wrap_hit | output | 1 | Page-wrapped second pointer read in this cycle |

## Verification
The bench builds two copies side by side, one with `FIX_WRAP = 0` and one with `FIX_WRAP = 1`. Each copy is driven with indirect jumps that sweep all 256 pointer low bytes on three pointer pages. Every page-end pointer, every ordinary pointer and a pointer whose +1 carries into the next page are therefore seen in both variants. Absolute jumps include a PC whose operand bytes lie across the 64 KiB boundary, and a non-jump opcode confirms that no bus activity follows.

// File: rtl/ind_jump_seq_pkg.sv
package ind_jump_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_OPC  = 3'd1,
    ST_LO   = 3'd2,
    ST_HI   = 3'd3,
    ST_P4   = 3'd4,
    ST_P5   = 3'd5,
    ST_P6   = 3'd6
  } step_t;
endpackage

// File: rtl/ind_jump_seq_step.sv
module ind_jump_seq_step
  import ind_jump_seq_pkg::*;
#(
  parameter bit FIX_WRAP = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_abs,
  input  logic  start_ind,
  output step_t step,
  output logic  ind,
  output logic  last
);
  always_comb begin
    last = 1'b0;
    if (step == ST_HI && !ind) last = 1'b1;
    if (step == ST_P5 && ind && !FIX_WRAP) last = 1'b1;
    if (step == ST_P6) last = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= ST_IDLE;
      ind  <= 1'b0;
    end else if (step == ST_IDLE) begin
      if (start_abs || start_ind) begin
        step <= ST_OPC;
        ind  <= start_ind;
      end
    end else if (last) begin
      step <= ST_IDLE;
    end else begin
      step <= step_t'(step + 3'd1);
    end
  end
endmodule

// File: rtl/ind_jump_seq_latch.sv
module ind_jump_seq_latch
  import ind_jump_seq_pkg::*;
#(
  parameter bit FIX_WRAP = 1'b0,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] pc_in,
  input  step_t             step,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] ptr,
  output logic [DATA_W-1:0] tgt_lo
);
  localparam step_t RD1_STEP = FIX_WRAP ? ST_P5 : ST_P4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      ptr    <= '0;
      tgt_lo <= '0;
    end else begin
      if (take) pc_q <= pc_in;
      if (step == ST_LO) ptr[DATA_W-1:0] <= rd_data;
      if (step == ST_HI) ptr[ADDR_W-1:DATA_W] <= rd_data;
      if (step == RD1_STEP) tgt_lo <= rd_data;
    end
  end
endmodule

// File: rtl/ind_jump_seq_addr.sv
module ind_jump_seq_addr
  import ind_jump_seq_pkg::*;
#(
  parameter bit FIX_WRAP = 1'b0,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2 * DATA_W
) (
  input  step_t             step,
  input  logic [ADDR_W-1:0] pc_q,
  input  logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] addr,
  output logic              page_wrapped
);
  logic [ADDR_W-1:0] second;
  logic [ADDR_W-1:0] ptr_inc;

  assign ptr_inc = ptr + ADDR_W'(1);

  generate
    if (FIX_WRAP) begin : g_full_inc
      assign second = ptr_inc;
    end else begin : g_page_inc
      logic [DATA_W-1:0] lo_inc;
      assign lo_inc = ptr[DATA_W-1:0] + DATA_W'(1);
      assign second = {ptr[ADDR_W-1:DATA_W], lo_inc};
    end
  endgenerate

  assign page_wrapped = (second != ptr_inc);

  always_comb begin
    case (step)
      ST_OPC:  addr = pc_q;
      ST_LO:   addr = pc_q + ADDR_W'(1);
      ST_HI:   addr = pc_q + ADDR_W'(2);
      ST_P4:   addr = ptr;
      ST_P5:   addr = FIX_WRAP ? ptr : second;
      ST_P6:   addr = second;
      default: addr = '0;
    endcase
  end
endmodule

// File: rtl/ind_jump_seq.sv
module ind_jump_seq
  import ind_jump_seq_pkg::*;
#(
  parameter bit       FIX_WRAP = 1'b0,
  parameter int       DATA_W   = 8,
  parameter int       ADDR_W   = 2 * DATA_W,
  parameter bit [7:0] OPC_ABS  = 8'h4C,
  parameter bit [7:0] OPC_IND  = 8'h6C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [7:0]        op_code,
  input  logic [ADDR_W-1:0] pc_in,
  output logic [ADDR_W-1:0] addr,
  output logic              rd_en,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] pc_out,
  output logic              pc_load,
  output logic              busy,
  output logic              wrap_hit
);
  step_t             step;
  logic              ind;
  logic              last;
  logic              take;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] tgt_lo;
  logic              page_wrapped;

  assign busy     = (step != ST_IDLE);
  assign op_ready = !busy;
  assign take     = op_valid && op_ready;
  assign rd_en    = busy;

  ind_jump_seq_step #(.FIX_WRAP(FIX_WRAP)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_abs (take && (op_code == OPC_ABS)),
    .start_ind (take && (op_code == OPC_IND)),
    .step      (step),
    .ind       (ind),
    .last      (last)
  );

  ind_jump_seq_latch #(.FIX_WRAP(FIX_WRAP), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .pc_in   (pc_in),
    .step    (step),
    .rd_data (rd_data),
    .pc_q    (pc_q),
    .ptr     (ptr),
    .tgt_lo  (tgt_lo)
  );

  ind_jump_seq_addr #(.FIX_WRAP(FIX_WRAP), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_addr (
    .step         (step),
    .pc_q         (pc_q),
    .ptr          (ptr),
    .addr         (addr),
    .page_wrapped (page_wrapped)
  );

  assign pc_load  = last;
  assign pc_out   = last ? {rd_data, (ind ? tgt_lo : ptr[DATA_W-1:0])} : '0;
  assign wrap_hit = last && ind && page_wrapped;
endmodule

// File: rtl/ind_jump_seq_chk.sv
module ind_jump_seq_chk #(
  parameter bit       FIX_WRAP = 1'b0,
  parameter int       ADDR_W   = 16,
  parameter bit [7:0] OPC_ABS  = 8'h4C,
  parameter bit [7:0] OPC_IND  = 8'h6C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic [7:0]        op_code,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic              pc_load,
  input logic              busy,
  input logic              wrap_hit
);
  localparam logic [3:0] IND_LAST = FIX_WRAP ? 4'd5 : 4'd4;
  logic [3:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (busy) cnt_q <= cnt_q + 4'd1;
    else cnt_q <= '0;
  end

  assert_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && (op_code == OPC_ABS || op_code == OPC_IND)) |=> busy);
  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !op_ready);
  assert_rden_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en == busy);
  assert_single_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load && !busy);
  assert_load_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> busy);
  assert_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && cnt_q != 4'd2) |-> (cnt_q == IND_LAST));
  assert_dummy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (FIX_WRAP && busy && cnt_q == 4'd3) |=> (addr == $past(addr)));
  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_hit |-> (pc_load && !FIX_WRAP));
  assert_wrap_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_hit |-> (cnt_q == 4'd4));
endmodule

bind ind_jump_seq ind_jump_seq_chk #(
  .FIX_WRAP (FIX_WRAP),
  .ADDR_W   (ADDR_W),
  .OPC_ABS  (OPC_ABS),
  .OPC_IND  (OPC_IND)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .op_code  (op_code),
  .addr     (addr),
  .rd_en    (rd_en),
  .pc_load  (pc_load),
  .busy     (busy),
  .wrap_hit (wrap_hit)
);

// File: tb/test_ind_jump_seq.sv
`timescale 1ns/100ps
module test_ind_jump_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v    [2];
  logic        rdy  [2];
  logic [7:0]  opc  [2];
  logic [15:0] pci  [2];
  logic [15:0] addr [2];
  logic        rden [2];
  logic [7:0]  rdat [2];
  logic [15:0] pco  [2];
  logic        pcl  [2];
  logic        bsy  [2];
  logic        wh   [2];

  logic [15:0] cur_pc  [2];
  logic [7:0]  cur_lo  [2];
  logic [7:0]  cur_hi  [2];

  int nvec = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] hashv(input logic [15:0] a);
    return a[7:0] + 8'(a[15:8] * 8'd3) + 8'h17;
  endfunction

  function automatic logic [7:0] mem(input int k, input logic [15:0] a);
    if (a == cur_pc[k] + 16'd1) return cur_lo[k];
    if (a == cur_pc[k] + 16'd2) return cur_hi[k];
    return hashv(a);
  endfunction

  always_comb rdat[0] = mem(0, addr[0]);
  always_comb rdat[1] = mem(1, addr[1]);

  ind_jump_seq #(.FIX_WRAP(1'b0)) i_ind_jump_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(v[0]), .op_ready(rdy[0]), .op_code(opc[0]),
    .pc_in(pci[0]), .addr(addr[0]), .rd_en(rden[0]), .rd_data(rdat[0]),
    .pc_out(pco[0]), .pc_load(pcl[0]), .busy(bsy[0]), .wrap_hit(wh[0]));

  ind_jump_seq #(.FIX_WRAP(1'b1)) i_ind_jump_seq_fix (
    .clk(clk), .rst_n(rst_n), .op_valid(v[1]), .op_ready(rdy[1]), .op_code(opc[1]),
    .pc_in(pci[1]), .addr(addr[1]), .rd_en(rden[1]), .rd_data(rdat[1]),
    .pc_out(pco[1]), .pc_load(pcl[1]), .busy(bsy[1]), .wrap_hit(wh[1]));

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  // one operation on copy k; sampling is done at falling edges
  task automatic run(input int k, input logic [7:0] code, input logic [15:0] pc,
                     input logic [7:0] lo, input logic [7:0] hi);
    logic [15:0] ea [7];
    logic [15:0] ptr, sec, exp_pc;
    int n;
    bit is_ind;
    cur_pc[k] = pc; cur_lo[k] = lo; cur_hi[k] = hi;
    is_ind = (code == 8'h6C);
    ptr = {hi, lo};
    ea[1] = pc; ea[2] = pc + 16'd1; ea[3] = pc + 16'd2;
    if (code == 8'h4C) begin
      n = 3; exp_pc = {hi, lo};
    end else if (is_ind && k == 0) begin
      n = 5; sec = {hi, 8'(lo + 8'd1)};
      ea[4] = ptr; ea[5] = sec;
      exp_pc = {hashv(sec), hashv(ptr)};
    end else if (is_ind) begin
      n = 6; sec = ptr + 16'd1;
      ea[4] = ptr; ea[5] = ptr; ea[6] = sec;
      exp_pc = {hashv(sec), hashv(ptr)};
    end else begin
      n = 0; exp_pc = '0;
    end
    chk(rdy[k] == 1'b1, "R1 ready while idle", 16'(rdy[k]), 16'd1);
    v[k] = 1'b1; opc[k] = code; pci[k] = pc;
    @(posedge clk); #1;
    v[k] = 1'b0;
    @(negedge clk);
    for (int c = 1; c <= n; c++) begin
      chk(bsy[k] && rden[k] && !rdy[k], "R2 busy/rd_en/ready in busy cycle",
          {13'd0, bsy[k], rden[k], rdy[k]}, 16'b110);
      if (c <= 3)
        chk(addr[k] == ea[c], is_ind ? "R4 operand address" : "R2 operand address", addr[k], ea[c]);
      else if (k == 0)
        chk(addr[k] == ea[c], "R5 pointer address", addr[k], ea[c]);
      else
        chk(addr[k] == ea[c], "R6 pointer/dummy address", addr[k], ea[c]);
      chk(pcl[k] == (c == n), "R3 pc_load only in last cycle", 16'(pcl[k]), 16'(c == n));
      chk(wh[k] == (c == n && is_ind && k == 0 && lo == 8'hFF), "R7 wrap_hit",
          16'(wh[k]), 16'(c == n && is_ind && k == 0 && lo == 8'hFF));
      if (c == n) chk(pco[k] == exp_pc, "R3 pc_out", pco[k], exp_pc);
      @(negedge clk);
    end
    if (n == 0)
      chk(!bsy[k] && !rden[k] && !pcl[k], "R8 dropped opcode, no bus cycle",
          {13'd0, bsy[k], rden[k], pcl[k]}, 16'd0);
    chk(!bsy[k] && !pcl[k] && rdy[k], "R1 idle after operation",
        {13'd0, bsy[k], pcl[k], rdy[k]}, 16'b001);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      v[k] = 1'b0; opc[k] = '0; pci[k] = '0;
      cur_pc[k] = 16'h9000; cur_lo[k] = '0; cur_hi[k] = '0;
    end
    repeat (3) @(negedge clk);
    for (int k = 0; k < 2; k++)
      chk(!bsy[k] && !rden[k] && !pcl[k] && !wh[k] && rdy[k] && addr[k] == 16'd0,
          "R9 state in reset", {11'd0, bsy[k], rden[k], pcl[k], wh[k], rdy[k]}, 16'b00001);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 2; k++)
      chk(!bsy[k] && rdy[k] && addr[k] == 16'd0, "R9 state after reset",
          {14'd0, bsy[k], rdy[k]}, 16'b01);
    for (int k = 0; k < 2; k++) begin
      run(k, 8'h4C, 16'h9000, 8'h34, 8'h12);
      run(k, 8'h4C, 16'hFFFE, 8'hCD, 8'hAB);
      run(k, 8'h4C, 16'hA0FF, 8'hFF, 8'h00);
      run(k, 8'hEA, 16'h9100, 8'h00, 8'h00);
      run(k, 8'h00, 16'h9200, 8'h00, 8'h00);
      foreach (cur_hi[j]) begin end
      for (int p = 0; p < 3; p++) begin
        for (int lo = 0; lo < 256; lo++) begin
          logic [7:0] hi;
          hi = (p == 0) ? 8'h00 : (p == 1) ? 8'h3F : 8'h7F;
          run(k, 8'h6C, 16'h9000 + 16'(lo * 7 + p), 8'(lo), hi);
        end
      end
    end
    summary();
    $finish;
  end
endmodule